// File: doc/BRIEF.md
# Subcode Q Capture and CRC Check

This block takes the Q-channel bit carried by each subcode frame of a compact disc and assembles a block of 96 Q bits. A block spans 98 frames: the first two are the sync frames and carry no Q data. The first 80 bits of a block are data and the last 16 are a CRC, sent inverted. At the end of every complete block the block checks that CRC, pulses a block clock and shows the pass or fail result on a level output.

Only a block that passes its check is copied into a stored register. An external controller reads that register serially, one bit per rising edge of its own shift clock. A mode pin selects the source of the serial port:

- Buffered mode: the port shows the stored block, which can be read at any time.
- Frame-synchronous mode: the port follows the Q bit of the latest frame, one frame-clock period at a time.

A block that passes while a buffered read is in progress is held back until the read wraps. The reader therefore never sees a block made of two halves.

Top module: `subq_capture`

## Requirements
- R1: `frame_clk` is a one-cycle pulse in the clock cycle after each cycle in which `frame_stb` is high.
- R2: A block starts after two consecutive frame strobes with `sync_in`=1. It then takes `q_bit` from the next 96 strobes with `sync_in`=0, first received bit first. `block_clk` pulses for one cycle in the cycle after the 96th such strobe. A single sync frame followed by a non-sync frame returns to hunting without starting a block.
- R3: The CRC uses x^16+x^12+x^5+1 with the register preset to zero. It runs over the 80 data bits, first bit first. The block passes when the last 16 bits, first received as the most significant, equal the bitwise inverse of the remainder. `crc_ok` changes only in the cycle `block_clk` is high: 1 means pass, 0 means fail.
- R4: A sync frame arriving while a block is being collected discards the partial block. No `block_clk` pulse follows and `crc_ok` keeps its value. That sync frame counts as the first of a new sync pair.
- R5: With `buf_mode`=1, `q_out` shows bit k of the stored block (k=0 is the first received bit). Here k is the number of `sclk_in` rising edges since the read began. A rising edge takes effect three clock edges after `sclk_in` is first sampled high. After the 96th edge the index wraps to 0.
- R6: The stored block is replaced only by a block that passed its CRC. A failed block leaves it unchanged.
- R7: While a buffered read is in progress (index not 0), a newly passed block is held pending. It is written one cycle after the index returns to 0. A later passing block replaces a pending one.
- R8: With `buf_mode`=0, `q_out` is the `q_bit` of the most recent strobe with `sync_in`=0, updated the cycle after that strobe. `sclk_in` has no effect and the read index is held at 0.
- R9: After reset `frame_clk`, `block_clk`, `crc_ok` and `q_out` are 0, and the stored block is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_stb | input | 1 | One-cycle strobe per subcode frame |
| sync_in | input | 1 | Marks the strobed frame as a sync frame |
| q_bit | input | 1 | Q-channel bit of the strobed frame |
| buf_mode | input | 1 | 1: buffered readout, 0: frame-synchronous readout |
| sclk_in | input | 1 | External shift clock for serial readout, asynchronous |
| frame_clk | output | 1 | Pulse per received frame |
| block_clk | output | 1 | Pulse per completed block |
| crc_ok | output | 1 | CRC result of the latest completed block |
| q_out | output | 1 | Serial Q data |

## Verification
The bench goes after four corner cases:

- A passing block that arrives mid-read. A design that wrote it at once would return a torn block, with later bits taken from the new one.
- A sync frame in the middle of a block. A design that kept counting would flag a block made of shifted bits, or would lose the following good block.
- A failed CRC. A design that stored it anyway would overwrite good data.
- The all-zero data block, whose sent CRC is all ones, and the wrap of the read index after 96 edges. Both show a polarity or off-by-one error as a wrong bit.

// File: rtl/subq_pkg.sv
package subq_pkg;

   typedef enum logic [1:0] {
      ST_HUNT    = 2'd0,
      ST_SYNC1   = 2'd1,
      ST_COLLECT = 2'd2
   } sq_state_t;

   localparam int unsigned DEF_FRAMES      = 98;
   localparam int unsigned DEF_SYNC_FRAMES = 2;
   localparam int unsigned DEF_CRC_W       = 16;
   localparam logic [15:0] DEF_CRC_POLY    = 16'h1021;

endpackage

// File: rtl/subq_crc.sv
module subq_crc #(
   parameter int unsigned       W    = 16,
   parameter logic [W-1:0]      POLY = 16'h1021
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         en,
   input  logic         din,
   output logic [W-1:0] rem
);

   logic fb;
   assign fb = rem[W-1] ^ din;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rem <= '0;
      else if (clr)
         rem <= '0;
      else if (en)
         rem <= {rem[W-2:0], 1'b0} ^ ({W{fb}} & POLY);
   end

   initial begin
      AST_CFG_CRC_WIDTH: assert (W >= 2) else $error("CRC width too small"); // R3
   end

endmodule

// File: rtl/subq_sync.sv
module subq_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise
);

   generate
      if (STAGES == 0) begin : g_direct
         logic prev;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev <= 1'b0;
            else        prev <= din;
         end
         assign rise = din & ~prev;
      end else begin : g_chain
         logic chain [STAGES];
         logic prev;
         for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)      chain[i] <= 1'b0;
               else if (i == 0) chain[i] <= din;
               else             chain[i] <= chain[(i == 0) ? 0 : i-1];
            end
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev <= 1'b0;
            else        prev <= chain[STAGES-1];
         end
         assign rise = chain[STAGES-1] & ~prev;
      end
   endgenerate

   AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise); // R5

endmodule

// File: rtl/subq_framer.sv
module subq_framer
   import subq_pkg::*;
#(
   parameter int unsigned          Q_BITS = 96,
   parameter int unsigned          CRC_W  = 16,
   parameter logic [CRC_W-1:0]     POLY   = 16'h1021
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_stb,
   input  logic              sync_in,
   input  logic              q_bit,
   output logic              frame_clk,
   output logic              block_clk,
   output logic              crc_ok,
   output logic              fin_stb,
   output logic              fin_good,
   output logic [Q_BITS-1:0] fin_data
);

   localparam int unsigned     DATA_BITS = Q_BITS - CRC_W;
   localparam int unsigned     CW        = $clog2(Q_BITS);
   localparam logic [CW-1:0]   LAST      = CW'(Q_BITS - 1);
   localparam logic [CW-1:0]   DLIM      = CW'(DATA_BITS);

   sq_state_t          state, nxt;
   logic [CW-1:0]      bitcnt;
   logic [Q_BITS-2:0]  sr;
   logic [CRC_W-1:0]   rem;
   logic [CRC_W-1:0]   rx_crc;
   logic               data_stb, sync_stb, in_col, crc_en;

   assign data_stb = frame_stb & ~sync_in;
   assign sync_stb = frame_stb & sync_in;
   assign in_col   = (state == ST_COLLECT);
   assign crc_en   = data_stb & in_col & (bitcnt < DLIM);

   assign fin_stb  = data_stb & in_col & (bitcnt == LAST);
   assign rx_crc   = {sr[CRC_W-2:0], q_bit};
   assign fin_good = (rx_crc == ~rem);
   assign fin_data = {sr, q_bit};

   subq_crc #(.W(CRC_W), .POLY(POLY)) u_crc (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (~in_col),
      .en    (crc_en),
      .din   (q_bit),
      .rem   (rem)
   );

   always_comb begin
      nxt = state;
      if (frame_stb) begin
         unique case (state)
            ST_HUNT:    nxt = sync_in ? ST_SYNC1 : ST_HUNT;
            ST_SYNC1:   nxt = sync_in ? ST_COLLECT : ST_HUNT;
            ST_COLLECT: begin
               if (sync_in)              nxt = ST_SYNC1;
               else if (bitcnt == LAST)  nxt = ST_HUNT;
            end
            default:    nxt = ST_HUNT;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_HUNT;
         bitcnt    <= '0;
         sr        <= '0;
         frame_clk <= 1'b0;
         block_clk <= 1'b0;
         crc_ok    <= 1'b0;
      end else begin
         state     <= nxt;
         frame_clk <= frame_stb;
         block_clk <= fin_stb;
         if (fin_stb)
            crc_ok <= fin_good;
         if (!in_col || sync_stb)
            bitcnt <= '0;
         else if (data_stb)
            bitcnt <= (bitcnt == LAST) ? '0 : bitcnt + 1'b1;
         if (data_stb && in_col)
            sr <= {sr[Q_BITS-3:0], q_bit};
      end
   end

   initial begin
      AST_CFG_BLOCK_SIZE: assert (Q_BITS > CRC_W + 1) else $error("block shorter than CRC"); // R2
   end

   AST_BITCNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      bitcnt <= LAST); // R2
   AST_BLOCK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      block_clk |=> !block_clk); // R2
   AST_CRC_AT_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(crc_ok) |-> block_clk); // R3
   AST_DISCARD_ON_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      (in_col && sync_stb) |=> !block_clk); // R4
   AST_BLOCK_WITH_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      block_clk |-> frame_clk); // R1

endmodule

// File: rtl/subq_readout.sv
module subq_readout #(
   parameter int unsigned Q_BITS = 96
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              buf_mode,
   input  logic              sclk_rise,
   input  logic              load,
   input  logic [Q_BITS-1:0] load_data,
   input  logic              fq_load,
   input  logic              fq_bit,
   output logic              q_out
);

   localparam int unsigned   IW    = $clog2(Q_BITS);
   localparam logic [IW-1:0] LASTI = IW'(Q_BITS - 1);

   logic [IW-1:0]     rd_idx;
   logic [Q_BITS-1:0] buf_q, pend_q;
   logic              pend, fq, busy, step, apply;

   assign busy  = (rd_idx != '0);
   assign step  = buf_mode & sclk_rise;
   assign apply = pend & ~busy & ~step;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_idx <= '0;
         buf_q  <= '0;
         pend_q <= '0;
         pend   <= 1'b0;
         fq     <= 1'b0;
      end else begin
         if (load) begin
            pend   <= 1'b1;
            pend_q <= load_data;
         end else if (apply) begin
            pend   <= 1'b0;
         end
         if (apply)
            buf_q <= pend_q;
         if (!buf_mode)
            rd_idx <= '0;
         else if (step)
            rd_idx <= (rd_idx == LASTI) ? '0 : rd_idx + 1'b1;
         if (fq_load)
            fq <= fq_bit;
      end
   end

   assign q_out = buf_mode ? buf_q[LASTI - rd_idx] : fq;

   AST_NO_TORN_READ: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(buf_q)); // R7
   AST_BUF_ONLY_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(buf_q) |-> $past(pend)); // R6
   AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_idx <= LASTI); // R5
   AST_FRAME_MODE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!buf_mode && !$past(buf_mode)) |-> !busy); // R8

endmodule

// File: rtl/subq_capture.sv
module subq_capture
   import subq_pkg::*;
#(
   parameter int unsigned          FRAMES_PER_BLOCK = DEF_FRAMES,
   parameter int unsigned          SYNC_FRAMES      = DEF_SYNC_FRAMES,
   parameter int unsigned          CRC_W            = DEF_CRC_W,
   parameter logic [CRC_W-1:0]     CRC_POLY         = DEF_CRC_POLY,
   parameter int unsigned          SCLK_STAGES      = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic frame_stb,
   input  logic sync_in,
   input  logic q_bit,
   input  logic buf_mode,
   input  logic sclk_in,
   output logic frame_clk,
   output logic block_clk,
   output logic crc_ok,
   output logic q_out
);

   localparam int unsigned Q_BITS = FRAMES_PER_BLOCK - SYNC_FRAMES;

   logic              fin_stb, fin_good, sclk_rise;
   logic [Q_BITS-1:0] fin_data;

   initial begin
      AST_CFG_SYNC_PAIR: assert (SYNC_FRAMES == 2) else $error("sync detector expects a pair"); // R2
      AST_CFG_CRC_FITS: assert (CRC_W < Q_BITS) else $error("CRC wider than block"); // R3
   end

   subq_framer #(.Q_BITS(Q_BITS), .CRC_W(CRC_W), .POLY(CRC_POLY)) u_framer (
      .clk       (clk),
      .rst_n     (rst_n),
      .frame_stb (frame_stb),
      .sync_in   (sync_in),
      .q_bit     (q_bit),
      .frame_clk (frame_clk),
      .block_clk (block_clk),
      .crc_ok    (crc_ok),
      .fin_stb   (fin_stb),
      .fin_good  (fin_good),
      .fin_data  (fin_data)
   );

   subq_sync #(.STAGES(SCLK_STAGES)) u_sclk (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (sclk_in),
      .rise  (sclk_rise)
   );

   subq_readout #(.Q_BITS(Q_BITS)) u_read (
      .clk       (clk),
      .rst_n     (rst_n),
      .buf_mode  (buf_mode),
      .sclk_rise (sclk_rise),
      .load      (fin_stb & fin_good),
      .load_data (fin_data),
      .fq_load   (frame_stb & ~sync_in),
      .fq_bit    (q_bit),
      .q_out     (q_out)
   );

endmodule

// File: tb/tb_subq_capture.sv
`timescale 1ns/1ps
module tb_subq_capture;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic frame_stb = 1'b0, sync_in = 1'b0, q_bit = 1'b0;
   logic buf_mode = 1'b1, sclk_in = 1'b0;
   logic frame_clk, block_clk, crc_ok, q_out;

   always #2.5 clk = ~clk;

   subq_capture dut (
      .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .sync_in(sync_in),
      .q_bit(q_bit), .buf_mode(buf_mode), .sclk_in(sclk_in),
      .frame_clk(frame_clk), .block_clk(block_clk), .crc_ok(crc_ok), .q_out(q_out)
   );

   int n_chk = 0, n_fail = 0, n_blk = 0;
   bit done = 0;

   task automatic check(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic check_int(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference ----------------
   function automatic logic [15:0] crc_calc(input logic [79:0] d, input int n);
      logic [15:0] c = 16'h0;
      for (int i = 0; i < n; i++) begin
         logic b = d[79-i];
         logic f = c[15] ^ b;
         c = {c[14:0], 1'b0} ^ (f ? 16'h1021 : 16'h0);
      end
      return c;
   endfunction

   int          m_st;
   bit          mq[$];
   logic [95:0] m_buf, m_pend_q;
   bit          m_pend;
   int          m_idx;
   bit          s1, s2, s3;
   bit          m_fclk, m_bclk, m_ok, m_fq;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_st = 0; mq.delete(); m_buf = '0; m_pend_q = '0; m_pend = 0;
         m_idx = 0; s1 = 0; s2 = 0; s3 = 0;
         m_fclk = 0; m_bclk = 0; m_ok = 0; m_fq = 0;
      end else begin
         bit rise, apply;
         rise  = s2 && !s3;
         apply = m_pend && (m_idx == 0) && !(rise && buf_mode);
         m_fclk = frame_stb;
         m_bclk = 0;
         if (apply) begin
            m_buf = m_pend_q;
            m_pend = 0;
         end
         if (!buf_mode) m_idx = 0;
         else if (rise) m_idx = (m_idx == 95) ? 0 : m_idx + 1;
         if (frame_stb) begin
            if (!sync_in) m_fq = q_bit;
            case (m_st)
               0: if (sync_in) m_st = 1;
               1: begin
                  if (sync_in) begin m_st = 2; mq.delete(); end
                  else m_st = 0;
               end
               default: begin
                  if (sync_in) begin
                     m_st = 1; mq.delete();
                  end else begin
                     mq.push_back(q_bit);
                     if (mq.size() == 96) begin
                        logic [95:0] blk;
                        for (int i = 0; i < 96; i++) blk[95-i] = mq[i];
                        m_bclk = 1;
                        m_ok = (blk[15:0] == ~crc_calc(blk[95:16], 80));
                        if (m_ok) begin m_pend = 1; m_pend_q = blk; end
                        m_st = 0;
                        mq.delete();
                     end
                  end
               end
            endcase
         end
         s3 = s2; s2 = s1; s1 = sclk_in;
      end
      #1;
      if (!done) begin
         check("R1 frame_clk", frame_clk, m_fclk);
         check("R2 block_clk", block_clk, m_bclk);
         check("R3 crc_ok", crc_ok, m_ok);
         if (buf_mode) check("R5 q_out buffered", q_out, m_buf[95-m_idx]);
         else          check("R8 q_out frame mode", q_out, m_fq);
         if (block_clk) n_blk++;
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic send_frame(input logic s, input logic b);
      @(negedge clk); frame_stb = 1'b1; sync_in = s; q_bit = b;
      @(negedge clk); frame_stb = 1'b0; sync_in = 1'b0; q_bit = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic send_bits(input logic [95:0] blk, input int n);
      for (int i = 0; i < n; i++) send_frame(1'b0, blk[95-i]);
   endtask

   task automatic send_block(input logic [95:0] blk);
      send_frame(1'b1, 1'b0);
      send_frame(1'b1, 1'b0);
      send_bits(blk, 96);
   endtask

   task automatic sclk_pulse();
      @(negedge clk); sclk_in = 1'b1;
      repeat (3) @(negedge clk);
      sclk_in = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   function automatic logic [95:0] make_blk(input logic [79:0] d, input bit good);
      logic [15:0] c = ~crc_calc(d, 80);
      if (!good) c[3] = ~c[3];
      return {d, c};
   endfunction

   task automatic finish_test();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      finish_test();
   end

   logic [95:0] blk_a, blk_b, blk_z, blk_c, blk_y;
   int base;

   initial begin
      blk_a = make_blk(80'hA5C3_0F1E_2D3C_4B5A_6978, 1);
      blk_b = make_blk(80'h1234_5678_9ABC_DEF0_1357, 0);
      blk_z = make_blk(80'h0, 1);
      blk_c = make_blk(80'h8001_7FFE_C3C3_3C3C_F00F, 1);
      blk_y = make_blk(80'h5A5A_FFFF_0000_1248_8421, 1);

      // known-answer self test of the bench CRC: "123456789" -> 31C3
      check_int("R3 crc known answer", int'(crc_calc({72'h31_3233_3435_3637_3839, 8'h0}, 72)), 16'h31C3);
      check("R3 zero data sends all-ones crc", blk_z[15:0] == 16'hFFFF, 1'b1);

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R9 reset frame_clk", frame_clk, 1'b0);
      check("R9 reset block_clk", block_clk, 1'b0);
      check("R9 reset crc_ok", crc_ok, 1'b0);
      check("R9 reset q_out", q_out, 1'b0);

      // good block
      send_block(blk_a);
      check("R3 good block passes", crc_ok, 1'b1);
      check_int("R2 one block counted", n_blk, 1);
      repeat (3) @(negedge clk);

      // buffered read of the whole block, then wrap
      for (int k = 0; k < 96; k++) begin
         check("R5 buffered bit", q_out, blk_a[95-k]);
         sclk_pulse();
      end
      check("R5 index wraps to first bit", q_out, blk_a[95]);

      // failed block leaves buffer alone
      send_block(blk_b);
      check("R3 bad block flagged", crc_ok, 1'b0);
      repeat (3) @(negedge clk);
      check("R6 buffer kept after fail", q_out, blk_a[95]);

      // partial block interrupted by sync, then restart using that sync
      base = n_blk;
      send_frame(1'b1, 1'b0);
      send_frame(1'b1, 1'b0);
      send_bits(blk_c, 40);
      send_frame(1'b1, 1'b0);
      check_int("R4 partial block not counted", n_blk, base);
      check("R4 crc_ok unchanged", crc_ok, 1'b0);
      send_frame(1'b1, 1'b0);
      send_bits(blk_c, 96);
      check_int("R4 restarted block counted", n_blk, base + 1);
      check("R4 restarted block passes", crc_ok, 1'b1);
      repeat (3) @(negedge clk);
      check("R6 buffer takes good block", q_out, blk_c[95]);

      // single sync followed by data: no block
      base = n_blk;
      send_frame(1'b1, 1'b0);
      send_bits(blk_a, 96);
      check_int("R2 lone sync starts nothing", n_blk, base);

      // all-zero data block
      send_block(blk_z);
      check("R3 zero block passes", crc_ok, 1'b1);
      repeat (3) @(negedge clk);
      check("R6 zero block stored", q_out, 1'b0);

      // deferred update during read
      send_block(blk_c);
      repeat (3) @(negedge clk);
      for (int k = 0; k < 10; k++) sclk_pulse();
      check("R5 mid read bit", q_out, blk_c[85]);
      send_block(blk_y);
      repeat (3) @(negedge clk);
      check("R7 read not torn", q_out, blk_c[85]);
      for (int k = 10; k < 95; k++) sclk_pulse();
      check("R7 last bit still old block", q_out, blk_c[0]);
      sclk_pulse();
      repeat (3) @(negedge clk);
      check("R7 pending block applied after wrap", q_out, blk_y[95]);
      sclk_pulse();
      check("R7 new block second bit", q_out, blk_y[94]);
      for (int k = 1; k < 96; k++) sclk_pulse();

      // frame synchronous mode
      @(negedge clk); buf_mode = 1'b0;
      send_frame(1'b0, 1'b1);
      check("R8 follows frame bit high", q_out, 1'b1);
      sclk_pulse(); sclk_pulse();
      check("R8 shift clock ignored", q_out, 1'b1);
      send_frame(1'b0, 1'b0);
      check("R8 follows frame bit low", q_out, 1'b0);
      repeat (4) @(negedge clk);
      buf_mode = 1'b1;
      @(negedge clk);
      check("R8 index held at zero", q_out, blk_y[95]);

      repeat (5) @(negedge clk);
      finish_test();
   end

endmodule